// File: doc/BRIEF.md
# Reset Sequencer with Power-up Timer

This block merges every reset source of a small microcontroller core into one active-high core reset. Power-on and brown-out flags arrive as asynchronous digital inputs from analog detectors. They force the reset at once and are released into a slow oscillator clock domain through a two-flop synchronizer. After either of them clears, a power-up timer adds a fixed hold-off of `PWRT_TICKS` slow-clock cycles. The default of 2048 cycles gives about 64 ms on a 31 kHz clock. A configuration bit with inverted sense bypasses the timer.

An active-low external reset pin passes through a sample-counting glitch filter. A second configuration bit disconnects the pin, which leaves only internal reset sources. A one-cycle watchdog pulse holds the core in reset for a short fixed time. It never drives the pin. A sticky four-bit cause register records which sources have fired since the last power-on.

Top module: `rst_seq`

## Requirements
- R1: While `por_i` or `bor_i` is high, `core_rst_o` is high with no clock edge needed. `por_i` also loads `cause_o` with 4'b0001 asynchronously.
- R2: When `por_i` and `bor_i` are both low and `cfg_pwrt_dis_i`=0, the flow is as follows. Two slow-clock edges after release, `pwrt_busy_o` rises. It stays high for exactly `PWRT_TICKS` cycles. `core_rst_o` falls on the same edge that `pwrt_busy_o` falls.
- R3: `core_rst_o` is high in every cycle in which `pwrt_busy_o` is high.
- R4: With `cfg_pwrt_dis_i`=1, `pwrt_busy_o` stays low and `core_rst_o` falls on the second slow-clock edge after `por_i` and `bor_i` are both low.
- R5: Pin resets and watchdog resets never start the power-up timer, so `pwrt_busy_o` stays low during and after them.
- R6: With `cfg_pin_en_i`=1, `pin_rst_n_i` must be sampled low on `FILT_LEN` consecutive edges to assert `core_rst_o`, which it does on the last of those edges. A shorter low pulse has no effect. Release needs `FILT_LEN` consecutive high samples.
- R7: With `cfg_pin_en_i`=0, the level on `pin_rst_n_i` has no effect on `core_rst_o` or `cause_o`.
- R8: `wdt_rst_i` sampled high on an edge makes `core_rst_o` high for exactly `WDT_HOLD` cycles from that edge. A new pulse during the hold restarts the hold.
- R9: `cause_o` bits are sticky and are cleared only by `por_i`. The bits are: bit0 power-on, bit1 brown-out (set on an edge with `bor_i` high), bit2 filtered pin reset, and bit3 watchdog.
- R10: A brown-out during the power-up count aborts the count. After `bor_i` clears, a full `PWRT_TICKS` count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Slow low-frequency oscillator clock |
| por_i | input | 1 | Power-on reset flag, async, active high |
| bor_i | input | 1 | Brown-out flag, async, active high |
| pin_rst_n_i | input | 1 | External reset pin level, active low |
| wdt_rst_i | input | 1 | Watchdog reset pulse, one clock wide |
| cfg_pin_en_i | input | 1 | 1: pin acts as reset input; 0: pin ignored |
| cfg_pwrt_dis_i | input | 1 | 1: power-up timer bypassed; 0: timer used |
| core_rst_o | output | 1 | Core reset, active high |
| pwrt_busy_o | output | 1 | Power-up timer counting |
| cause_o | output | 4 | Sticky reset cause flags |

## Verification
The power-up hold-off can overlap with a watchdog hold or with a filtered pin reset, because they are independent sources. The bench fires a watchdog pulse in the middle of the timer count. It then checks that the timer's length and the release cycle do not change, and that the cause register still records the watchdog. In a second run, it drives the pin low so the filter asserts one edge before the timer expires. It then checks that the core reset spans both sources without a gap and drops exactly `FILT_LEN` edges after the pin returns high.

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq #(
  parameter int PWRT_TICKS = 2048,
  parameter int FILT_LEN   = 4,
  parameter int WDT_HOLD   = 2
) (
  input  logic       clk_lf,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       pin_rst_n_i,
  input  logic       wdt_rst_i,
  input  logic       cfg_pin_en_i,
  input  logic       cfg_pwrt_dis_i,
  output logic       core_rst_o,
  output logic       pwrt_busy_o,
  output logic [3:0] cause_o
);
  localparam int TW = $clog2(PWRT_TICKS + 1);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int WW = $clog2(WDT_HOLD + 1);

  logic          arst;
  logic [1:0]    sync;
  logic          hold;
  logic          run;
  logic [TW-1:0] tcnt;
  logic          pin_low, pin_rst;
  logic [FW-1:0] fcnt;
  logic [WW-1:0] wcnt;
  logic          wdt_act;

  assign arst    = por_i | bor_i;
  assign hold    = sync[1];
  assign pin_low = cfg_pin_en_i & ~pin_rst_n_i;
  assign wdt_act = (wcnt != '0);

  always_ff @(posedge clk_lf or posedge arst)
    if (arst) sync <= 2'b11;
    else      sync <= {sync[0], 1'b0};

  always_ff @(posedge clk_lf or posedge arst)
    if (arst) begin
      run  <= 1'b1;
      tcnt <= '0;
    end else if (!hold && run) begin
      if (cfg_pwrt_dis_i || tcnt == TW'(PWRT_TICKS - 1)) run <= 1'b0;
      tcnt <= tcnt + 1'b1;
    end

  assign pwrt_busy_o = run & ~hold & ~cfg_pwrt_dis_i;

  always_ff @(posedge clk_lf or posedge arst)
    if (arst) begin
      pin_rst <= 1'b0;
      fcnt    <= '0;
    end else if (pin_low != pin_rst) begin
      if (fcnt == FW'(FILT_LEN - 1)) begin
        pin_rst <= pin_low;
        fcnt    <= '0;
      end else fcnt <= fcnt + 1'b1;
    end else fcnt <= '0;

  always_ff @(posedge clk_lf or posedge arst)
    if (arst)           wcnt <= '0;
    else if (wdt_rst_i) wcnt <= WW'(WDT_HOLD);
    else if (wdt_act)   wcnt <= wcnt - 1'b1;

  always_ff @(posedge clk_lf or posedge por_i)
    if (por_i) cause_o <= 4'b0001;
    else begin
      if (bor_i)     cause_o[1] <= 1'b1;
      if (pin_rst)   cause_o[2] <= 1'b1;
      if (wdt_rst_i) cause_o[3] <= 1'b1;
    end

  assign core_rst_o = arst | hold | (run & ~cfg_pwrt_dis_i) | pin_rst | wdt_act;

  a_r3_busy_in_reset: assert property (@(posedge clk_lf) disable iff (arst)
    pwrt_busy_o |-> core_rst_o);

  a_r2_full_count: assert property (@(posedge clk_lf) disable iff (arst)
    ($fell(pwrt_busy_o) && !cfg_pwrt_dis_i && !hold) |-> ($past(tcnt) == TW'(PWRT_TICKS - 1)));

  a_r5_no_restart: assert property (@(posedge clk_lf) disable iff (arst)
    !run |=> !run);

  a_r6_filter_len: assert property (@(posedge clk_lf) disable iff (arst)
    $rose(pin_rst) |-> ($past(pin_low) && $past(fcnt) == FW'(FILT_LEN - 1)));

  a_r8_wdt_start: assert property (@(posedge clk_lf) disable iff (arst)
    wdt_rst_i |=> core_rst_o);

  a_r8_wdt_end: assert property (@(posedge clk_lf) disable iff (arst)
    (wcnt == WW'(1) && !wdt_rst_i) |=> !wdt_act);

  a_r9_sticky: assert property (@(posedge clk_lf) disable iff (por_i)
    (cause_o & $past(cause_o)) == $past(cause_o));
endmodule

// File: tb/sim_rst_seq.sv
`timescale 1ns/1ps
module sim_rst_seq;
  localparam int T = 16;
  localparam int F = 4;
  localparam int W = 2;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic por = 0, bor = 0, pin_n = 1, wdt = 0, pen = 1, pdis = 1;
  logic core, busy;
  logic [3:0] cause;
  int nchk = 0, nfail = 0;
  bit done = 0;

  rst_seq #(.PWRT_TICKS(T), .FILT_LEN(F), .WDT_HOLD(W)) u0 (
    .clk_lf(clk), .por_i(por), .bor_i(bor), .pin_rst_n_i(pin_n), .wdt_rst_i(wdt),
    .cfg_pin_en_i(pen), .cfg_pwrt_dis_i(pdis),
    .core_rst_o(core), .pwrt_busy_o(busy), .cause_o(cause));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic power_up(bit dis);
    pdis = dis; por = 1; tick(2); por = 0;
    tick(dis ? 2 : T + 2);
  endtask

  initial begin
    #1 por = 1;
    pdis = 0;
    tick(2);
    chk("R1 core during por", core, 1);
    chk("R1 cause after por", cause, 1);
    chk("R2 busy during por", busy, 0);

    por = 0;
    for (int k = 1; k <= T + 4; k++) begin
      tick();
      chk("R2 busy window", busy, (k >= 2 && k <= T + 1));
      chk("R2 core release", core, (k <= T + 1));
      if (k >= 2 && k <= T + 1) chk("R3 core while busy", core, 1);
    end
    chk("R9 cause after power-up", cause, 1);

    bor = 1; #1;
    chk("R1 async brown-out", core, 1);
    tick(2);
    chk("R9 brown-out bit sticky", cause, 4'b0011);
    bor = 0; tick(T + 4);

    for (int d = 0; d <= 1; d++)
      for (int bl = 1; bl <= 3; bl++) begin
        pdis = d[0];
        bor = 1; tick(bl); bor = 0;
        for (int k = 1; k <= T + 3; k++) begin
          tick();
          chk(d ? "R4 bypass release" : "R2 release after brown-out", core, d ? (k <= 1) : (k <= T + 1));
          chk(d ? "R4 busy stays low" : "R2 busy after brown-out", busy, d ? 0 : (k >= 2 && k <= T + 1));
        end
      end

    pdis = 0;
    bor = 1; tick(); bor = 0;
    tick(10);
    chk("R10 counting before abort", busy, 1);
    bor = 1; tick(); bor = 0;
    for (int k = 1; k <= T + 3; k++) begin
      tick();
      chk("R10 full recount", core, (k <= T + 1));
    end

    for (int en = 0; en <= 1; en++)
      for (int len = 1; len <= 7; len++) begin
        bit asrt;
        pen = 1; power_up(0);
        chk("R2 idle before pin test", core, 0);
        pen = en[0];
        pin_n = 0;
        for (int k = 1; k <= len; k++) begin
          tick();
          chk(en ? "R6 pin assert" : "R7 pin ignored", core, (en == 1 && k >= F));
          chk("R5 pin never starts timer", busy, 0);
        end
        pin_n = 1;
        asrt = (en == 1 && len >= F);
        for (int j = 1; j <= F + 1; j++) begin
          tick();
          chk(en ? "R6 pin release" : "R7 pin ignored", core, (asrt && j < F));
          chk("R5 no timer after pin", busy, 0);
        end
        chk(en ? "R9 pin cause" : "R7 no pin cause", cause, asrt ? 4'b0101 : 4'b0001);
      end
    pen = 1;

    power_up(0);
    for (int g = 0; g <= 2; g++) begin
      tick(g);
      wdt = 1; tick(); wdt = 0;
      chk("R8 watchdog start", core, 1);
      for (int k = 1; k <= 3; k++) begin
        tick();
        chk("R8 watchdog length", core, (k < W));
        chk("R5 watchdog never starts timer", busy, 0);
      end
      chk("R9 watchdog cause", cause, 4'b1001);
    end
    wdt = 1; tick(); wdt = 0; tick();
    wdt = 1; tick(); wdt = 0;
    chk("R8 retrigger", core, 1);
    tick(); chk("R8 retrigger hold", core, 1);
    tick(); chk("R8 retrigger end", core, 0);

    pdis = 0; por = 1; tick(2); por = 0;
    for (int k = 1; k <= T + 4; k++) begin
      wdt = (k == 5);
      tick();
      chk("R2 busy with watchdog overlap", busy, (k >= 2 && k <= T + 1));
      chk("R3 core with watchdog overlap", core, (k <= T + 1));
    end
    wdt = 0;
    chk("R9 watchdog cause during timer", cause, 4'b1001);

    por = 1; tick(2); por = 0;
    for (int k = 1; k <= T + 16; k++) begin
      pin_n = !(k >= T - 2 && k <= T + 8);
      tick();
      chk("R6 pin overlaps timer", core, (k <= T + 11));
    end
    pin_n = 1;
    chk("R9 pin cause after overlap", cause, 4'b0101);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R2: actual 0 expected 1 sequence completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule